// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

This block gathers up to 32 asynchronous interrupt request lines and merges them into two processor-facing outputs: a normal request and a critical request. Each request line has its own settings for polarity, for level or edge detection, for routing to one of the two outputs, and for enable. Every line first passes through a two-stage synchronizer. The synchronized line is then turned into a pending bit, which software acknowledges by writing a one to that bit.

A fixed-priority encoder picks one winner from the lines that are both pending and enabled. It combines the winner's index with a programmable base word to form a vector. A configuration bit selects the direction of the priority order: either line 0 or the highest-numbered line wins. Software reaches every register over a flat bus with an address, a write strobe and write data. Read data is combinational.

Top module: `pirq_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following hold. The pending, enable, routing and edge-select registers read zero. The polarity register reads all ones. The vector configuration word (address 5) reads 0x00000001. Both request outputs are low, and the vector reads 0.
- R2: A write to the pending register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged, unless the same source sets that bit again in the same cycle.
- R3: A pending bit drives neither output while its enable bit (address 1) is 0. An enable register of all zeros keeps both outputs low, and the pending bits are still recorded.
- R4: Routing bit (address 2) equal to 0 sends a pending, enabled source to the normal output. Routing bit equal to 1 sends it to the critical output.
- R5: Polarity bit (address 3) equal to 1 makes a source active when its input is high. Polarity bit equal to 0 makes it active when its input is low.
- R6: Edge-select bit (address 4) equal to 0 selects level mode. In level mode the pending bit is set every cycle the synchronized source is active, so a clearing write has no effect while the source stays active.
- R7: Edge-select bit equal to 1 selects edge mode. The pending bit is set on the inactive-to-active transition of the synchronized input, on the third rising clock edge after the input changes. It stays set after the input returns to inactive.
- R8: Bit 0 of the configuration word selects the priority order. With bit 0 = 1, the lowest-numbered pending, enabled source wins. With bit 0 = 0, the highest-numbered one wins.
- R9: The vector (address 6 and port vec_out) is the configuration base, bits 31:7, OR'd with the winner index shifted left by 2. When no enabled source is pending, the index field is zero. Base bits 6:1 read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous interrupt request lines |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_normal | output | 1 | Non-critical interrupt request |
| irq_crit | output | 1 | Critical interrupt request |
| vec_out | output | 32 | Base plus winning source index |

## Verification
A corrupted pending bit or enable mask appears on irq_normal or irq_crit in the same cycle, because both outputs are combinational from the registers. A wrong polarity or detection mode appears in the pending register three clock edges after the input changes. An error in the priority encoder or in the base masking appears at once on vec_out. The same value can be read through the vector address, so order reversal and the idle-index case are each observed by direct comparison.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    parameter int unsigned NUM_SRC   = 32;
    parameter int unsigned DATA_W    = 32;
    parameter int unsigned ADDR_W    = 3;
    parameter int unsigned VEC_SHIFT = 2;
    parameter int unsigned SYNC_LEN  = 2;

    localparam int unsigned IDX_W    = $clog2(NUM_SRC);
    localparam int unsigned BASE_LSB = IDX_W + VEC_SHIFT;
    localparam logic [DATA_W-1:0] BASE_MASK = {DATA_W{1'b1}} << BASE_LSB;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PEND  = 3'd0,
        SEL_ENA   = 3'd1,
        SEL_ROUTE = 3'd2,
        SEL_POL   = 3'd3,
        SEL_EDGE  = 3'd4,
        SEL_VCFG  = 3'd5,
        SEL_VEC   = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] ena;
        logic [NUM_SRC-1:0] route;
        logic [NUM_SRC-1:0] pol;
        logic [NUM_SRC-1:0] edge_sel;
    } src_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic              low_first;
    } vec_cfg_t;

    function automatic logic [DATA_W-1:0] make_vector(input logic [DATA_W-1:0] base,
                                                      input logic [IDX_W-1:0]  idx);
        return (base & BASE_MASK) | (DATA_W'(idx) << VEC_SHIFT);
    endfunction
endpackage

// File: rtl/pirq_front.sv
module pirq_front
    import pirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_raw,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] edge_sel,
    output logic [NUM_SRC-1:0] set_req
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [SYNC_LEN-1:0] sync_q;
        logic                act;
        logic                act_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                act_q  <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_LEN-2:0], irq_raw[s]};
                act_q  <= act;
            end
        end

        // active level after polarity: high-active when pol is 1
        assign act = pol[s] ? sync_q[SYNC_LEN-1] : ~sync_q[SYNC_LEN-1];

        always_comb begin
            if (edge_sel[s]) set_req[s] = act & ~act_q;
            else             set_req[s] = act;
        end
    end
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] set_req,
    input  logic [DATA_W-1:0]  vec_word,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_SRC-1:0] pend,
    output src_cfg_t           cfg,
    output vec_cfg_t           vcfg
);
    logic               wr_pend;
    logic [NUM_SRC-1:0] clr_mask;

    assign wr_pend  = bus_wr && (bus_addr == SEL_PEND);
    assign clr_mask = wr_pend ? bus_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            // a set in the same cycle wins over a clearing write
            pend <= (pend & ~clr_mask) | set_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.ena        <= '0;
            cfg.route      <= '0;
            cfg.pol        <= '1;
            cfg.edge_sel   <= '0;
            vcfg.base      <= '0;
            vcfg.low_first <= 1'b1;
        end else if (bus_wr) begin
            case (bus_addr)
                SEL_ENA:   cfg.ena      <= bus_wdata[NUM_SRC-1:0];
                SEL_ROUTE: cfg.route    <= bus_wdata[NUM_SRC-1:0];
                SEL_POL:   cfg.pol      <= bus_wdata[NUM_SRC-1:0];
                SEL_EDGE:  cfg.edge_sel <= bus_wdata[NUM_SRC-1:0];
                SEL_VCFG: begin
                    vcfg.base      <= bus_wdata & BASE_MASK;
                    vcfg.low_first <= bus_wdata[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            SEL_PEND:  bus_rdata = DATA_W'(pend);
            SEL_ENA:   bus_rdata = DATA_W'(cfg.ena);
            SEL_ROUTE: bus_rdata = DATA_W'(cfg.route);
            SEL_POL:   bus_rdata = DATA_W'(cfg.pol);
            SEL_EDGE:  bus_rdata = DATA_W'(cfg.edge_sel);
            SEL_VCFG:  bus_rdata = vcfg.base | DATA_W'(vcfg.low_first);
            SEL_VEC:   bus_rdata = vec_word;
            default:   bus_rdata = '0;
        endcase
    end

    // R2: bits written as one are gone next cycle unless re-set
    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (rst)
        wr_pend |=> ((pend & $past(bus_wdata[NUM_SRC-1:0]) & ~$past(set_req)) == '0));

    // R6: a requesting source is pending next cycle regardless of writes
    p_set_sticks_r6: assert property (@(posedge clk) disable iff (rst)
        (|set_req) |=> ((pend & $past(set_req)) == $past(set_req)));
endmodule

// File: rtl/pirq_prio.sv
module pirq_prio
    import pirq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic               low_first,
    output logic               any_req,
    output logic [IDX_W-1:0]   win_idx
);
    logic [IDX_W-1:0] idx_lo;
    logic [IDX_W-1:0] idx_hi;

    // scan downwards so the lowest requesting index is written last
    always_comb begin
        idx_lo = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx_lo = IDX_W'(i);
        end
    end

    // scan upwards so the highest requesting index is written last
    always_comb begin
        idx_hi = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) idx_hi = IDX_W'(i);
        end
    end

    assign any_req = |req;
    assign win_idx = low_first ? idx_lo : idx_hi;
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
    import pirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_normal,
    output logic               irq_crit,
    output logic [DATA_W-1:0]  vec_out
);
    logic [NUM_SRC-1:0] set_req;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] live;
    src_cfg_t           cfg;
    vec_cfg_t           vcfg;
    logic               any_req;
    logic [IDX_W-1:0]   win_idx;

    pirq_front u_front (
        .clk      (clk),
        .rst      (rst),
        .irq_raw  (irq_in),
        .pol      (cfg.pol),
        .edge_sel (cfg.edge_sel),
        .set_req  (set_req)
    );

    pirq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .set_req   (set_req),
        .vec_word  (vec_out),
        .bus_rdata (bus_rdata),
        .pend      (pend),
        .cfg       (cfg),
        .vcfg      (vcfg)
    );

    assign live = pend & cfg.ena;

    pirq_prio u_prio (
        .req       (live),
        .low_first (vcfg.low_first),
        .any_req   (any_req),
        .win_idx   (win_idx)
    );

    assign irq_normal = |(live & ~cfg.route);
    assign irq_crit   = |(live & cfg.route);
    assign vec_out    = make_vector(vcfg.base, win_idx);

    // R3: nothing enabled means no request on either output
    p_mask_gates_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.ena == '0) |-> (!irq_normal && !irq_crit));

    // R8: the chosen index always names a live source
    p_winner_live_r8: assert property (@(posedge clk) disable iff (rst)
        any_req |-> live[win_idx]);

    // R9: idle vector is the bare base
    p_idle_vec_r9: assert property (@(posedge clk) disable iff (rst)
        !any_req |-> (vec_out == vcfg.base));
endmodule

// File: tb/tb_pirq_ctrl.sv
module tb_pirq_ctrl;
    import pirq_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_SRC-1:0] irq_in;
    logic [ADDR_W-1:0]  bus_addr;
    logic               bus_wr;
    logic [DATA_W-1:0]  bus_wdata;
    logic [DATA_W-1:0]  bus_rdata;
    logic               irq_normal;
    logic               irq_crit;
    logic [DATA_W-1:0]  vec_out;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pirq_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_normal(irq_normal), .irq_crit(irq_crit), .vec_out(vec_out)
    );

    // level-mode polarity vectors: input, polarity, expected pending after clear
    typedef struct packed {
        logic [31:0] pin;
        logic [31:0] pol;
        logic [31:0] exp;
    } lvl_vec_t;

    localparam int NV = 5;
    localparam lvl_vec_t TBL [NV] = '{
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001},
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000},
        '{32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_0001},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        '{32'h0000_F0F0, 32'h0000_FF00, 32'hFFFF_F00F}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; irq_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); check("R1 pend", v, 32'h0);
        rd(3'd1, v); check("R1 ena", v, 32'h0);
        rd(3'd2, v); check("R1 route", v, 32'h0);
        rd(3'd3, v); check("R1 pol", v, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R1 edge", v, 32'h0);
        rd(3'd5, v); check("R1 vcfg", v, 32'h0000_0001);
        rd(3'd6, v); check("R1 vec", v, 32'h0);
        check("R1 outs", {30'h0, irq_normal, irq_crit}, 32'h0);

        // R5/R6 table walk: level mode, polarity, clear ignored while active
        for (int k = 0; k < NV; k++) begin
            @(negedge clk) irq_in = TBL[k].pin;
            wr(3'd3, TBL[k].pol);
            repeat (4) @(negedge clk);
            wr(3'd0, 32'hFFFF_FFFF);
            rd(3'd0, v);
            check($sformatf("R5 R6 level vec %0d", k), v, TBL[k].exp);
            @(negedge clk) irq_in = '0;
            wr(3'd3, 32'hFFFF_FFFF);
            repeat (4) @(negedge clk);
            wr(3'd0, 32'hFFFF_FFFF);
        end
        rd(3'd0, v); check("R2 table cleanup", v, 32'h0);

        // R3 enable masking, R4 routing
        @(negedge clk) irq_in = 32'h0000_0008;
        repeat (4) @(negedge clk);
        rd(3'd0, v); check("R3 pend recorded", v, 32'h0000_0008);
        check("R3 outs masked", {30'h0, irq_normal, irq_crit}, 32'h0);
        wr(3'd1, 32'h0000_0008);
        #1 check("R4 normal route", {30'h0, irq_normal, irq_crit}, 32'h2);
        wr(3'd2, 32'h0000_0008);
        #1 check("R4 crit route", {30'h0, irq_normal, irq_crit}, 32'h1);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'h0);

        // R8 / R9 priority order and vector
        @(negedge clk) irq_in = 32'h0000_0210;
        repeat (4) @(negedge clk);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R6 level kept", v, 32'h0000_0210);
        wr(3'd5, 32'h1234_56FF);
        rd(3'd5, v); check("R9 base mask", v, 32'h1234_5681);
        wr(3'd1, 32'h0000_0210);
        rd(3'd6, v); check("R8 low first", v, 32'h1234_5690);
        wr(3'd5, 32'h1234_5680);
        rd(3'd6, v); check("R8 high first", v, 32'h1234_56A4);
        check("R8 port vec", vec_out, 32'h1234_56A4);
        wr(3'd1, 32'h0);
        rd(3'd6, v); check("R9 idle vec", v, 32'h1234_5680);

        @(negedge clk) irq_in = '0;
        repeat (4) @(negedge clk);
        wr(3'd0, 32'hFFFF_FFFF);

        // R7 edge mode latency and latch, R2 clearing
        wr(3'd4, 32'h0000_0020);
        wr(3'd1, 32'h0000_0020);
        @(negedge clk);
        bus_addr = 3'd0;
        irq_in = 32'h0000_0020;
        @(posedge clk); @(posedge clk);
        #1 check("R7 not yet", bus_rdata, 32'h0);
        @(posedge clk);
        #1 check("R7 edge set", bus_rdata, 32'h0000_0020);
        @(negedge clk) irq_in = '0;
        repeat (4) @(negedge clk);
        rd(3'd0, v); check("R7 held", v, 32'h0000_0020);
        check("R7 normal out", {31'h0, irq_normal}, 32'h1);
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, v); check("R2 zero write", v, 32'h0000_0020);
        wr(3'd0, 32'h0000_0020);
        rd(3'd0, v); check("R2 one write", v, 32'h0);
        check("R2 out drop", {31'h0, irq_normal}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule